// File: doc/BRIEF.md
# Pausable Serial Register Write Port

This block is the receiving end of a serial write path. An external host drives a serial clock, a data line, an active-low frame strobe and a one-bit target select. Each write carries a 24-bit word, most significant bit first. When the word is complete, the block loads it into either a control register or a calibration register. A fast system clock oversamples every host line through two-flop synchronisers. The bit clock's rising edges are found in the system clock domain.

The host may release the frame strobe in the middle of a word, during a low phase of the serial clock. Bit-clock edges that arrive while the strobe is high are ignored. When the strobe is asserted again, capture resumes at the next bit. A word shorter than 24 bits never reaches a register.

The target select is taken with the first bit of each word. If it moves later in the same word, a sticky error flag is set, and the word still goes to the target chosen at its start. The write path does not observe or drive any data-ready status.

Top module: `ser_wr_port`

## Requirements
- R1: While `rst` is high and after it is released, `ctrl_q`, `cal_q`, `wr_done` and `sel_err` are all zero.
- R2: Data is captured on rising edges of `sclk_i` while `tfs_n_i` is low, most significant bit first. The target register takes the whole 24-bit word on the 24th such edge.
- R3: If `asel_i` is 0 at the first bit, the word goes to `ctrl_q`. If it is 1, the word goes to `cal_q`. The other register keeps its value.
- R4: The target is fixed by `asel_i` at the first bit of the word. A later change of `asel_i` within the word does not redirect the word.
- R5: A word with fewer than 24 captured bits changes no register and produces no `wr_done` pulse.
- R6: If `tfs_n_i` goes high in the middle of a word and later returns low, the bit position is kept. Capture continues with the next bit, and the finished word equals the 24 bits sent.
- R7: Rising edges of `sclk_i` while `tfs_n_i` is high do not shift data and do not advance the bit position.
- R8: `wr_done` is high for exactly one system clock cycle per completed word, in the cycle in which the target register shows the new word.
- R9: `sel_err` becomes 1 if `asel_i` differs from its first-bit value at any later bit of a word. It then stays 1 until reset.
- R10: A reset in the middle of a word discards the partial bits. The next word starts at bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock from host, idles low |
| sdata_i | input | 1 | Serial data, MSB first |
| tfs_n_i | input | 1 | Active-low transfer frame strobe |
| asel_i | input | 1 | Target select: 0 control, 1 calibration |
| ctrl_q | output | 24 | Control register contents |
| cal_q | output | 24 | Calibration register contents |
| wr_done | output | 1 | One-cycle pulse when a word is loaded |
| sel_err | output | 1 | Sticky flag: target select moved mid-word |

## Verification
The hardest case to reach from the ports is a word that is suspended and resumed. In that case the host keeps toggling the bit clock and changes the data line while the strobe is high, and those edges must leave no trace. The stimulus sweeps the pause point over every bit position from 1 to 23 and drives junk bits and clock edges during each pause. It then checks that the completed word matches a value computed in the bench. A select change is injected late in a word to confirm that the word still goes to its first-bit target.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;
  typedef enum logic {
    TGT_CTRL = 1'b0,
    TGT_CAL  = 1'b1
  } tgt_e;
endpackage

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_wr_deser.sv
module ser_wr_deser
  import ser_wr_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              tfs_n,
  input  logic              asel,
  output logic              load_v,
  output logic [WORD_W-1:0] load_data,
  output tgt_e              load_tgt,
  output logic              sel_err
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic              sclk_d;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sreg;
  tgt_e              tgt;
  logic              cap;

  assign cap = sclk & ~sclk_d & ~tfs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      cnt       <= '0;
      sreg      <= '0;
      tgt       <= TGT_CTRL;
      sel_err   <= 1'b0;
      load_v    <= 1'b0;
      load_data <= '0;
      load_tgt  <= TGT_CTRL;
    end else begin
      sclk_d <= sclk;
      load_v <= 1'b0;
      if (cap) begin
        sreg <= {sreg[WORD_W-2:0], sdata};
        if (cnt == '0) tgt <= tgt_e'(asel);
        else if (tgt_e'(asel) != tgt) sel_err <= 1'b1;
        if (cnt == LAST) begin
          cnt       <= '0;
          load_v    <= 1'b1;
          load_data <= {sreg[WORD_W-2:0], sdata};
          load_tgt  <= tgt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser_wr_regs.sv
module ser_wr_regs
  import ser_wr_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_v,
  input  logic [WORD_W-1:0] load_data,
  input  tgt_e              load_tgt,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] cal_q,
  output logic              wr_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cal_q   <= '0;
      wr_done <= 1'b0;
    end else begin
      wr_done <= load_v;
      if (load_v) begin
        case (load_tgt)
          TGT_CTRL: ctrl_q <= load_data;
          TGT_CAL:  cal_q  <= load_data;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_wr_port.sv
module ser_wr_port
  import ser_wr_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              tfs_n_i,
  input  logic              asel_i,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] cal_q,
  output logic              wr_done,
  output logic              sel_err
);
  localparam int NSIG = 4;

  logic [NSIG-1:0]   raw, syn;
  logic              load_v;
  logic [WORD_W-1:0] load_data;
  tgt_e              load_tgt;

  assign raw = {asel_i, tfs_n_i, sdata_i, sclk_i};

  ser_wr_sync #(
    .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  ser_wr_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst(rst),
    .sclk(syn[0]), .sdata(syn[1]), .tfs_n(syn[2]), .asel(syn[3]),
    .load_v(load_v), .load_data(load_data), .load_tgt(load_tgt),
    .sel_err(sel_err)
  );

  ser_wr_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst),
    .load_v(load_v), .load_data(load_data), .load_tgt(load_tgt),
    .ctrl_q(ctrl_q), .cal_q(cal_q), .wr_done(wr_done)
  );
endmodule

// File: rtl/ser_wr_port_chk.sv
module ser_wr_port_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] ctrl_q,
  input logic [WORD_W-1:0] cal_q,
  input logic              wr_done,
  input logic              sel_err
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);
  // R5
  ctrl_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_q) |-> wr_done);
  // R5
  cal_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cal_q) |-> wr_done);
  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(ctrl_q) && !$stable(cal_q)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err);
endmodule

bind ser_wr_port ser_wr_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .cal_q(cal_q),
  .wr_done(wr_done), .sel_err(sel_err)
);

// File: tb/ser_wr_port_test.sv
`timescale 1ns/1ps
module ser_wr_port_test;
  localparam int W = 24;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, tfs_n = 1'b1, asel = 1'b0;
  logic [W-1:0] ctrl_q, cal_q;
  logic wr_done, sel_err;
  int checks = 0, errors = 0, pulses = 0;
  logic [W-1:0] exp_ctrl = '0, exp_cal = '0;

  always #4 clk = ~clk;

  ser_wr_port uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata),
    .tfs_n_i(tfs_n), .asel_i(asel), .ctrl_q(ctrl_q), .cal_q(cal_q),
    .wr_done(wr_done), .sel_err(sel_err)
  );

  always @(negedge clk) if (!rst && wr_done) pulses++;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdata = b; sclk = 1'b0; waitc(4);
    sclk = 1'b1; waitc(4);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] w, input int from, input int upto);
    for (int i = from; i < upto; i++) bit_out(w[W-1-i]);
  endtask

  task automatic full(input logic sel, input logic [W-1:0] w);
    asel = sel; tfs_n = 1'b0;
    send(w, 0, W);
    waitc(2); tfs_n = 1'b1; waitc(8);
    if (sel) exp_cal = w; else exp_ctrl = w;
  endtask

  task automatic do_reset();
    rst = 1'b1; sclk = 1'b0; tfs_n = 1'b1; waitc(4);
    rst = 1'b0; waitc(4);
    exp_ctrl = '0; exp_cal = '0; pulses = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitc(3);
    chk("R1 ctrl in reset", ctrl_q, '0);
    chk("R1 cal in reset", cal_q, '0);
    do_reset();
    chk("R1 ctrl after reset", ctrl_q, '0);
    chk("R1 flags after reset", {22'd0, wr_done, sel_err}, '0);

    // R2 R3 R8: walking-one and patterned words to both targets
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] w;
      int p0;
      w = (24'h1 << i) ^ (i[0] ? 24'hA5A5A5 : 24'h0);
      p0 = pulses;
      full(i[1], w);
      chk("R2 ctrl word", ctrl_q, exp_ctrl);
      chk("R3 cal word", cal_q, exp_cal);
      chk("R8 one pulse", 24'(pulses - p0), 24'd1);
    end
    chk("R9 no error on clean words", {23'd0, sel_err}, '0);

    // R6 R7: pause at every position, junk edges during the pause
    for (int k = 1; k < W; k++) begin
      logic [W-1:0] w;
      int p0;
      w = 24'hC3_5A_0F ^ (24'(k) * 24'h010203);
      p0 = pulses;
      asel = k[0]; tfs_n = 1'b0;
      send(w, 0, k);
      waitc(2); tfs_n = 1'b1; waitc(2);
      for (int j = 0; j < 3; j++) bit_out(~w[j]);
      waitc(2); tfs_n = 1'b0; waitc(2);
      send(w, k, W);
      waitc(2); tfs_n = 1'b1; waitc(8);
      if (k[0]) exp_cal = w; else exp_ctrl = w;
      chk("R6 resumed word ctrl", ctrl_q, exp_ctrl);
      chk("R7 resumed word cal", cal_q, exp_cal);
      chk("R6 one pulse", 24'(pulses - p0), 24'd1);
    end

    // R5: 23 bits only, no update; the 24th bit completes it
    begin
      logic [W-1:0] w;
      int p0;
      w = 24'h13579B;
      p0 = pulses;
      asel = 1'b0; tfs_n = 1'b0;
      send(w, 0, W - 1);
      waitc(2); tfs_n = 1'b1; waitc(10);
      chk("R5 partial no ctrl update", ctrl_q, exp_ctrl);
      chk("R5 partial no pulse", 24'(pulses - p0), 24'd0);
      tfs_n = 1'b0; send(w, W - 1, W); waitc(2); tfs_n = 1'b1; waitc(8);
      exp_ctrl = w;
      chk("R5 completed word", ctrl_q, exp_ctrl);
    end

    // R4 R9: select moves mid-word
    begin
      logic [W-1:0] w;
      w = 24'h2468AC;
      asel = 1'b1; tfs_n = 1'b0;
      send(w, 0, 12);
      asel = 1'b0;
      send(w, 12, W);
      waitc(2); tfs_n = 1'b1; waitc(8);
      exp_cal = w;
      chk("R4 word kept first target", cal_q, exp_cal);
      chk("R4 other target untouched", ctrl_q, exp_ctrl);
      chk("R9 error set", {23'd0, sel_err}, 24'd1);
      full(1'b0, 24'h0F0F0F);
      chk("R9 error sticky", {23'd0, sel_err}, 24'd1);
    end

    // R10: reset mid-word discards partial bits
    begin
      logic [W-1:0] w;
      tfs_n = 1'b0; asel = 1'b0;
      send(24'hFFFFFF, 0, 7);
      do_reset();
      chk("R10 error cleared", {23'd0, sel_err}, 24'd0);
      w = 24'h800001;
      full(1'b0, w);
      chk("R10 fresh word", ctrl_q, exp_ctrl);
      chk("R10 cal still zero", cal_q, '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule